// File: doc/BRIEF.md
# Decimating Peak-of-Group Correlation Buffer

This block sits behind a synchronization correlator. It takes a stream of correlation magnitudes, keeps only the largest value from each run of `GROUP` consecutive samples, and stores that value in a single-port buffer. The buffer has one slot per group across one repetition period of the searched signal. With the defaults, a period of 9600 magnitudes is reduced to 1200 slots.

A start pulse arms a search. The first period after a start or a clear writes the group maxima directly into the buffer. Each later period adds its new maxima into the stored slots, so the values build up non-coherently over repetitions. A running peak tracker follows the largest slot and its index as the writes go by. When the last slot of a period has been written, the block pulses a done strobe and presents the peak index and peak value, which give a coarse timing estimate. It raises a detect flag when the peak exceeds a threshold. If `MAX_PERIODS` periods go by without a detection, it raises a give-up flag instead. Either outcome stops the search until the next start.

Top module: `pkdec_top`

## Requirements
- R1: While reset is held and after it is released, `peakIdx`, `peakVal`, `periodDone`, `detect` and `giveUp` are all zero, and the search is not armed.
- R2: Each buffer slot receives the maximum of the `GROUP` consecutive accepted samples that belong to it. Slot k covers accepted samples k*GROUP to k*GROUP+GROUP-1 of the period.
- R3: In the first period after a start or a clear, every slot is overwritten with its group maximum. The reported `peakVal` is the largest slot and `peakIdx` is its 0-based slot number.
- R4: In each later period, every slot becomes its stored value plus the new group maximum. The sum saturates at 2^ACC_W-1 and never wraps.
- R5: When slots tie for the peak, the lowest slot index is reported.
- R6: `periodDone` is a one-cycle pulse. It is high in the cycle after the second rising edge that follows the edge accepting the last sample of a period. `peakIdx`, `peakVal` and `detect` update in that same cycle and hold until the next pulse, start or clear.
- R7: `detect` is set at a period end when the accumulated peak is strictly greater than `threshIn`. The search then stops, and later samples produce no `periodDone` and leave the outputs unchanged.
- R8: `giveUp` is set at the end of the `MAX_PERIODS`-th period when that period gives no detection. `detect` takes priority, and the search then stops.
- R9: A clear pulse returns the period count and the slot position to zero and forces the next period to overwrite. It also zeroes `detect`, `giveUp`, `peakIdx` and `peakVal`, and it leaves the armed state as it was.
- R10: `magValid` is ignored while no search is armed: before the first start and after a detection or give-up.
- R11: `magValid` may drop for any number of cycles between samples without changing how samples are grouped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| magIn | input | MAG_W | Correlation magnitude |
| magValid | input | 1 | `magIn` carries a sample this cycle |
| startIn | input | 1 | Arm a new search and restart the period |
| clearIn | input | 1 | Restart the period count with overwrite; armed state kept |
| threshIn | input | ACC_W | Detection threshold (strict greater-than) |
| peakIdx | output | IDX_W | Slot index of the accumulated peak |
| peakVal | output | ACC_W | Accumulated peak value |
| periodDone | output | 1 | One-cycle pulse at each period end |
| detect | output | 1 | Peak exceeded the threshold |
| giveUp | output | 1 | Period limit reached without detection |

## Verification
Each result is due at a fixed distance from the stimulus that causes it. The period-end report, made up of the done pulse, peak index, peak value and both flags, appears two rising edges after the edge that accepts the final sample of a period. The level effects of a start or a clear appear one edge after the pulse. The bench's driver records the expected report and its due cycle in a queue whenever it sends the last sample of a period to an armed search. A monitor that samples at falling edges pops an entry each time the done pulse appears, compares the cycle number and all the values, and reports any done pulse that arrives with no entry waiting. Ignored traffic is checked both by that same unexpected-pulse check and by direct reads of the held flags and values afterwards.

// File: rtl/pkdec_pkg.sv
package pkdec_pkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic restart;   // start or clear this cycle
    logic grpTake;   // sample accepted
    logic grpFirst;  // accepted sample opens a group
    logic grpClose;  // accepted sample closes a group
    logic rdEn;      // read slot
    logic wrEn;      // write slot
    logic ovw;       // overwrite instead of accumulate
    logic firstEnt;  // slot being written is slot 0
    logic report;    // slot being written is the last of the period
  } ctrl_strobe_t;

endpackage

// File: rtl/pkdec_ctrl.sv
module pkdec_ctrl
  import pkdec_pkg::*;
#(
  parameter int GROUP       = 8,
  parameter int ENTRIES     = 1200,
  parameter int MAX_PERIODS = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int GCNT_W = $clog2(GROUP),
  localparam int PCNT_W = $clog2(MAX_PERIODS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             magValid,
  input  logic             startIn,
  input  logic             clearIn,
  input  logic             hit,
  output ctrl_strobe_t     stb,
  output logic [IDX_W-1:0] addr,
  output logic             periodDone,
  output logic             giveUp
);

  localparam logic [GCNT_W-1:0] GLAST = GCNT_W'(GROUP - 1);
  localparam logic [IDX_W-1:0]  ELAST = IDX_W'(ENTRIES - 1);
  localparam logic [PCNT_W-1:0] PLAST = PCNT_W'(MAX_PERIODS - 1);

  logic              active;
  logic              ovwMode;
  logic [GCNT_W-1:0] gCnt;
  logic [IDX_W-1:0]  eIdx;
  logic [PCNT_W-1:0] pCnt;

  logic              rdStage, rdFirst, rdLast;
  logic [IDX_W-1:0]  rdAddr;
  logic              wrStage, wrFirst, wrLast;
  logic [IDX_W-1:0]  wrAddr;

  logic restart, take, closeGrp, report;

  always_comb begin
    restart  = startIn | clearIn;
    take     = active & magValid & ~restart;
    closeGrp = take & (gCnt == GLAST);
    report   = wrStage & wrLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active     <= 1'b0;
      ovwMode    <= 1'b1;
      gCnt       <= '0;
      eIdx       <= '0;
      pCnt       <= '0;
      rdStage    <= 1'b0;
      rdFirst    <= 1'b0;
      rdLast     <= 1'b0;
      rdAddr     <= '0;
      wrStage    <= 1'b0;
      wrFirst    <= 1'b0;
      wrLast     <= 1'b0;
      wrAddr     <= '0;
      giveUp     <= 1'b0;
      periodDone <= 1'b0;
    end else if (restart) begin
      if (startIn) active <= 1'b1;
      ovwMode    <= 1'b1;
      gCnt       <= '0;
      eIdx       <= '0;
      pCnt       <= '0;
      rdStage    <= 1'b0;
      wrStage    <= 1'b0;
      giveUp     <= 1'b0;
      periodDone <= 1'b0;
    end else begin
      if (take) begin
        gCnt <= closeGrp ? '0 : gCnt + 1'b1;
        if (closeGrp) eIdx <= (eIdx == ELAST) ? '0 : eIdx + 1'b1;
      end
      // read stage, then write stage
      rdStage <= closeGrp;
      if (closeGrp) begin
        rdAddr  <= eIdx;
        rdFirst <= (eIdx == '0);
        rdLast  <= (eIdx == ELAST);
      end
      wrStage <= rdStage;
      if (rdStage) begin
        wrAddr  <= rdAddr;
        wrFirst <= rdFirst;
        wrLast  <= rdLast;
      end
      periodDone <= report;
      if (report) begin
        ovwMode <= 1'b0;
        if (hit) begin
          active <= 1'b0;
        end else if (pCnt == PLAST) begin
          giveUp <= 1'b1;
          active <= 1'b0;
        end else begin
          pCnt <= pCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    stb.restart  = restart;
    stb.grpTake  = take;
    stb.grpFirst = (gCnt == '0);
    stb.grpClose = closeGrp;
    stb.rdEn     = rdStage;
    stb.wrEn     = wrStage;
    stb.ovw      = ovwMode;
    stb.firstEnt = wrFirst;
    stb.report   = report;
    addr         = rdStage ? rdAddr : wrAddr;
  end

  // R6
  period_done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodDone |=> !periodDone);

  // R8
  giveup_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(giveUp) |-> periodDone);

  // R10
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !restart) |=> ($stable(gCnt) && $stable(eIdx)));

endmodule

// File: rtl/pkdec_dpath.sv
module pkdec_dpath
  import pkdec_pkg::*;
#(
  parameter int MAG_W   = 12,
  parameter int ACC_W   = 16,
  parameter int ENTRIES = 1200,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [MAG_W-1:0] magIn,
  input  logic [ACC_W-1:0] threshIn,
  input  ctrl_strobe_t     stb,
  input  logic [IDX_W-1:0] addr,
  output logic             hit,
  output logic [IDX_W-1:0] peakIdx,
  output logic [ACC_W-1:0] peakVal,
  output logic             detect
);

  logic [MAG_W-1:0] grpMax, closeMax, newMax;
  logic [ACC_W-1:0] newExt, rdData, wrVal, accSat;
  logic [ACC_W:0]   sumWide;
  logic [ACC_W-1:0] peakRun, candVal;
  logic [IDX_W-1:0] peakRunIdx, candIdx;
  logic             takeNew;
  logic [ACC_W-1:0] slotMem [ENTRIES];

  // group comparator
  always_comb begin
    if (stb.grpFirst)          closeMax = magIn;
    else if (magIn > grpMax)   closeMax = magIn;
    else                       closeMax = grpMax;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grpMax <= '0;
      newMax <= '0;
    end else begin
      if (stb.grpTake)  grpMax <= closeMax;
      if (stb.grpClose) newMax <= closeMax;
    end
  end

  generate
    if (ACC_W > MAG_W) begin : g_ext
      assign newExt = {{(ACC_W - MAG_W){1'b0}}, newMax};
    end else begin : g_same
      assign newExt = newMax;
    end
  endgenerate

  // single-port slot memory, read then write on separate cycles
  always_ff @(posedge clk) begin
    if (stb.rdEn) rdData <= slotMem[addr];
    if (stb.wrEn) slotMem[addr] <= wrVal;
  end

  always_comb begin
    sumWide = {1'b0, rdData} + {1'b0, newExt};
    accSat  = sumWide[ACC_W] ? {ACC_W{1'b1}} : sumWide[ACC_W-1:0];
    wrVal   = stb.ovw ? newExt : accSat;
    takeNew = stb.firstEnt | (wrVal > peakRun);
    candVal = takeNew ? wrVal : peakRun;
    candIdx = takeNew ? addr  : peakRunIdx;
    hit     = candVal > threshIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      peakRun    <= '0;
      peakRunIdx <= '0;
      peakVal    <= '0;
      peakIdx    <= '0;
      detect     <= 1'b0;
    end else if (stb.restart) begin
      peakVal <= '0;
      peakIdx <= '0;
      detect  <= 1'b0;
    end else if (stb.wrEn) begin
      peakRun    <= candVal;
      peakRunIdx <= candIdx;
      if (stb.report) begin
        peakVal <= candVal;
        peakIdx <= candIdx;
        detect  <= hit;
      end
    end
  end

  // R4
  sat_no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn && !stb.ovw) |-> (wrVal >= rdData));

  // R6
  single_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.rdEn && stb.wrEn));

  // R7
  detect_on_report_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(detect) |-> $past(stb.report));

endmodule

// File: rtl/pkdec_top.sv
module pkdec_top
  import pkdec_pkg::*;
#(
  parameter int MAG_W       = 12,
  parameter int ACC_W       = 16,
  parameter int GROUP       = 8,
  parameter int ENTRIES     = 1200,
  parameter int MAX_PERIODS = 16,
  localparam int IDX_W      = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [MAG_W-1:0] magIn,
  input  logic             magValid,
  input  logic             startIn,
  input  logic             clearIn,
  input  logic [ACC_W-1:0] threshIn,
  output logic [IDX_W-1:0] peakIdx,
  output logic [ACC_W-1:0] peakVal,
  output logic             periodDone,
  output logic             detect,
  output logic             giveUp
);

  ctrl_strobe_t     stb;
  logic [IDX_W-1:0] addr;
  logic             hit;

  pkdec_ctrl #(
    .GROUP(GROUP), .ENTRIES(ENTRIES), .MAX_PERIODS(MAX_PERIODS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .magValid(magValid), .startIn(startIn),
    .clearIn(clearIn), .hit(hit), .stb(stb), .addr(addr),
    .periodDone(periodDone), .giveUp(giveUp)
  );

  pkdec_dpath #(
    .MAG_W(MAG_W), .ACC_W(ACC_W), .ENTRIES(ENTRIES)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .magIn(magIn), .threshIn(threshIn),
    .stb(stb), .addr(addr), .hit(hit), .peakIdx(peakIdx),
    .peakVal(peakVal), .detect(detect)
  );

  // R8
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(detect && giveUp));

endmodule

// File: tb/pkdec_top_tb.sv
module pkdec_top_tb;

  localparam int MAG_W = 8;
  localparam int ACC_W = 9;
  localparam int GROUP = 4;
  localparam int ENTRIES = 8;
  localparam int MAX_PERIODS = 4;
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int SATV = (1 << ACC_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [MAG_W-1:0] magIn = '0;
  logic magValid = 1'b0, startIn = 1'b0, clearIn = 1'b0;
  logic [ACC_W-1:0] threshIn = '0;
  logic [IDX_W-1:0] peakIdx;
  logic [ACC_W-1:0] peakVal;
  logic periodDone, detect, giveUp;

  always #10 clk = ~clk;

  pkdec_top #(
    .MAG_W(MAG_W), .ACC_W(ACC_W), .GROUP(GROUP),
    .ENTRIES(ENTRIES), .MAX_PERIODS(MAX_PERIODS)
  ) u_dut (
    .clk(clk), .rstN(rstN), .magIn(magIn), .magValid(magValid),
    .startIn(startIn), .clearIn(clearIn), .threshIn(threshIn),
    .peakIdx(peakIdx), .peakVal(peakVal), .periodDone(periodDone),
    .detect(detect), .giveUp(giveUp)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  // reference model state
  int  accM [ENTRIES];
  bit  armedM = 0;
  bit  firstM = 1;
  int  perM = 0;
  int  thrM = 0;

  // scoreboard queues
  int qCyc[$], qIdx[$], qVal[$], qDet[$], qGu[$];
  string qTag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int genVal(int pat, int p, int e, int g);
    case (pat)
      0: return (e * 37 + g * 11 + p * 53) % 200;
      1: return ((e == 2 || e == 5) && g == 1) ? 100 : 10 + e;
      default: return 255;
    endcase
  endfunction

  // driver: one full period, gap idle cycles after each sample
  task automatic sendPeriod(int pat, int gap, string tag);
    int gm;
    for (int e = 0; e < ENTRIES; e++) begin
      gm = 0;
      for (int g = 0; g < GROUP; g++) begin
        int v;
        v = genVal(pat, perM, e, g);
        if (v > gm) gm = v;
        @(negedge clk);
        magIn = MAG_W'(v);
        magValid = 1'b1;
        if (armedM && e == ENTRIES - 1 && g == GROUP - 1) begin
          accM[e] = firstM ? gm : ((accM[e] + gm > SATV) ? SATV : accM[e] + gm);
          pushExpect(cyc + 3, tag);
        end
        for (int k = 0; k < gap; k++) begin
          @(negedge clk);
          magValid = 1'b0;
        end
      end
      if (armedM && e != ENTRIES - 1)
        accM[e] = firstM ? gm : ((accM[e] + gm > SATV) ? SATV : accM[e] + gm);
    end
    @(negedge clk);
    magValid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pushExpect(int dueCyc, string tag);
    int pk, pi;
    bit det, gu;
    pk = accM[0];
    pi = 0;
    for (int i = 1; i < ENTRIES; i++)
      if (accM[i] > pk) begin pk = accM[i]; pi = i; end
    perM++;
    det = (pk > thrM);
    gu = !det && (perM == MAX_PERIODS);
    firstM = 0;
    if (det || gu) armedM = 0;
    qCyc.push_back(dueCyc); qIdx.push_back(pi); qVal.push_back(pk);
    qDet.push_back(int'(det)); qGu.push_back(int'(gu)); qTag.push_back(tag);
  endtask

  // partial period (no model update; followed by clear)
  task automatic sendPartial(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      magIn = MAG_W'(200 - i);
      magValid = 1'b1;
    end
    @(negedge clk);
    magValid = 1'b0;
  endtask

  task automatic pulse(bit isStart, int thr);
    @(negedge clk);
    threshIn = ACC_W'(thr);
    thrM = thr;
    magValid = 1'b0;
    if (isStart) startIn = 1'b1; else clearIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    clearIn = 1'b0;
    if (isStart) armedM = 1;
    firstM = 1;
    perM = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && periodDone && !finished) begin
      if (qCyc.size() == 0) begin
        check(1'b0, "R10/R7 unexpected periodDone", 1, 0);
      end else begin
        int ec, ei, ev, ed, eg;
        string t;
        ec = qCyc.pop_front(); ei = qIdx.pop_front(); ev = qVal.pop_front();
        ed = qDet.pop_front(); eg = qGu.pop_front(); t = qTag.pop_front();
        check(cyc == ec, {"R6 timing ", t}, cyc, ec);
        check(int'(peakIdx) == ei, {"peakIdx ", t}, int'(peakIdx), ei);
        check(int'(peakVal) == ev, {"peakVal ", t}, int'(peakVal), ev);
        check(int'(detect) == ed, {"R7 detect ", t}, int'(detect), ed);
        check(int'(giveUp) == eg, {"R8 giveUp ", t}, int'(giveUp), eg);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 20000 && !finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) accM[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state during reset
    check(peakIdx == '0 && peakVal == '0, "R1 peak outputs in reset", int'(peakVal), 0);
    check(!periodDone && !detect && !giveUp, "R1 flags in reset",
          int'({periodDone, detect, giveUp}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!periodDone && !detect && !giveUp && peakVal == '0, "R1 after release",
          int'({periodDone, detect, giveUp}), 0);

    // R10: not armed, samples ignored
    sendPeriod(0, 0, "R10 unarmed");
    check(peakVal == '0 && !detect, "R10 outputs untouched while unarmed", int'(peakVal), 0);

    // R2 R3 R4 R8: never-detect threshold, run to give-up
    pulse(1, SATV);
    sendPeriod(0, 0, "R3 R2 first period overwrite");
    sendPeriod(0, 0, "R4 accumulate p2");
    sendPeriod(0, 0, "R4 accumulate p3");
    sendPeriod(0, 0, "R8 final period");
    check(giveUp == 1'b1, "R8 giveUp held", int'(giveUp), 1);
    // R10: ignored after give-up
    sendPeriod(0, 0, "R10 after giveUp");
    check(giveUp == 1'b1 && !detect, "R10 flags held after giveUp", int'(giveUp), 1);

    // R5 ties and R7 detection
    pulse(1, 250);
    check(!giveUp && !detect, "R9 start clears flags", int'({detect, giveUp}), 0);
    sendPeriod(1, 0, "R5 tie p1");
    sendPeriod(1, 0, "R5 tie p2");
    sendPeriod(1, 0, "R7 detect p3");
    check(detect == 1'b1, "R7 detect held", int'(detect), 1);
    sendPeriod(1, 0, "R7 ignored after detect");
    check(detect == 1'b1 && int'(peakVal) == 300 && int'(peakIdx) == 2,
          "R7 outputs unchanged after detect", int'(peakVal), 300);

    // R9 clear zeroes outputs, keeps unarmed
    pulse(0, 250);
    check(!detect && peakVal == '0 && peakIdx == '0, "R9 clear zeroes outputs",
          int'(peakVal), 0);
    sendPeriod(1, 0, "R9 clear keeps unarmed");

    // R11 gaps, then R9 mid-period clear with overwrite, R4 saturation
    pulse(1, SATV);
    sendPeriod(0, 2, "R11 gapped samples");
    sendPartial(6);
    pulse(0, SATV);
    sendPeriod(2, 0, "R9 overwrite after clear");
    sendPeriod(2, 1, "R4 second sum");
    sendPeriod(2, 0, "R4 saturation");
    sendPeriod(2, 0, "R8 give up after clear");

    repeat (5) @(negedge clk);
    check(qCyc.size() == 0, "R6 all expected reports seen", qCyc.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule